// File: doc/BRIEF.md
# Display Controller Control and Status Unit

This block is the register-level control core of a raster display controller. Software programs a control word through a simple read/write register port. The word holds a run bit, a panel-type bit, a line-clear select bit, a two-bit load-mode field and per-source interrupt enables. The pixel pipeline reports its events on a strobe vector. The block collects them into a sticky status word and drives two things: the enable that the pipeline sees, and one level interrupt line.

A three-state machine controls shutdown. The states are `ST_IDLE`, `ST_RUN` and `ST_DRAIN`. The transitions are: start (`ST_IDLE`→`ST_RUN`, software writes run=1), stop request (`ST_RUN`→`ST_DRAIN`, software writes run=0), cancel (`ST_DRAIN`→`ST_RUN`, software writes run=1 again) and frame complete (`ST_DRAIN`→`ST_IDLE`, end-of-frame strobe). Clearing the run bit therefore does not cut the pipeline off in mid-frame. The pipeline keeps running until the current frame ends, and then the block raises the done status. Each status bit has its own clear policy. Some bits clear when software writes 1 to them. The error bits clear only when the controller goes idle. The palette-loaded bit clears on a write only in palette-only mode.

Top module: `dc_ctrl_core`

## Requirements
- R1: The control register is at word address 0 and the status register at word address 1. In the control register, bit 0 is run, bits 6:2 are interrupt enables (2 vsync, 3 done, 4 palette loaded, 5 line-not-irq, 6 line), bit 7 is panel type, bit 10 is line-clear select and bits 21:20 are the load mode. A read returns the value written to these bits, and every other bit reads 0. All registers reset to 0.
- R2: Writing run=1 while idle moves the machine to `ST_RUN`. `pipe_en_o` is high in `ST_RUN` and in `ST_DRAIN`, and low in `ST_IDLE`.
- R3: Writing run=0 in `ST_RUN` moves the machine to `ST_DRAIN`. The run bit then reads back 0, but `pipe_en_o` stays high until `evt_i[0]` (end of frame) is seen. On that edge the machine returns to `ST_IDLE` and status bit 0 (done) is set.
- R4: Done stays set through idle cycles and through status writes. It is cleared on the edge where a run=1 write starts the machine from idle.
- R5: A run=1 write during `ST_DRAIN` returns the machine to `ST_RUN`. A later end-of-frame strobe then neither sets done nor stops the pipeline.
- R6: The status bit positions are: 1 vsync, 2 sync lost, 3 AC-bias count, 4 line match, 5 FIFO underflow and 6 palette loaded. The strobe on `evt_i[n]` sets status bit n, but only outside `ST_IDLE`. `evt_i[0]` never sets a status bit while the machine is in `ST_RUN`.
- R7: Status bits 1, 3 and 4 are cleared by writing 1 to their positions in the status register.
- R8: Status bits 2 and 5 ignore status writes. They are cleared on each clock edge at which the machine is in `ST_IDLE`.
- R9: Status bit 6 clears on a write of 1 only when the load mode is 01 (palette only). With load mode 10 (frame only) or 00 (palette then frame) it ignores such writes. In every load mode it is cleared on each edge spent in `ST_IDLE`.
- R10: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R11: `irq_o` is registered and goes high one cycle after any of these holds: done with its enable set, vsync with its enable set, palette loaded with its enable set, line match with its enable set, sync lost, or FIFO underflow. The AC-bias bit never raises `irq_o`.
- R12: `drain_o` is high exactly in `ST_DRAIN`, that is, while the pipeline runs its final frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data (combinational from address) |
| evt_i | input | 7 | Pipeline event strobes; bit 0 end of frame, bits 6:1 status events |
| pipe_en_o | output | 1 | Enable to the pixel pipeline |
| drain_o | output | 1 | Final frame in progress |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults, DATA_W=32 and ADDR_W=2. At that width the load-mode field at bits 21:20 exists, so the palette clear rule can be tested in palette-only mode and in frame-only mode, and the top interrupt-enable bit can be read back. Each directed scenario drives the shutdown path through drain, cancel and completion. It also times each status clear against the idle state, and it checks that the interrupt appears exactly one cycle after its status bit.

// File: rtl/dc_pkg.sv
package dc_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} dc_state_e;
    typedef enum logic [1:0] {CLR_START, CLR_W1C, CLR_IDLE, CLR_PAL} dc_clr_e;

    localparam int C_RUN      = 0;
    localparam int C_IE_VSYNC = 2;
    localparam int C_IE_DONE  = 3;
    localparam int C_IE_PAL   = 4;
    localparam int C_IE_LINE  = 6;
    localparam int C_PANEL    = 7;
    localparam int C_LCLR     = 10;
    localparam int C_LMODE    = 20;

    localparam int S_DONE  = 0;
    localparam int S_VSYNC = 1;
    localparam int S_SYNCL = 2;
    localparam int S_ACB   = 3;
    localparam int S_LINE  = 4;
    localparam int S_FUF   = 5;
    localparam int S_PAL   = 6;
    localparam int STAT_W  = 7;

    localparam logic [1:0] LM_PAL_ONLY = 2'b01;

    function automatic dc_clr_e clr_kind(input int b);
        if (b == S_DONE) return CLR_START;
        if (b == S_SYNCL || b == S_FUF) return CLR_IDLE;
        if (b == S_PAL) return CLR_PAL;
        return CLR_W1C;
    endfunction
endpackage

// File: rtl/dc_ctrl_fsm.sv
module dc_ctrl_fsm
    import dc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_wr_i,
    input  logic      run_val_i,
    input  logic      frame_end_i,
    output dc_state_e state_o,
    output logic      start_o,
    output logic      done_set_o,
    output logic      pipe_en_o,
    output logic      drain_o
);
    dc_state_e state_q, state_d;
    logic go_req, stop_req;

    assign go_req   = run_wr_i && run_val_i;
    assign stop_req = run_wr_i && !run_val_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go_req) state_d = ST_RUN;
            ST_RUN:   if (stop_req) state_d = ST_RUN == ST_RUN ? ST_DRAIN : ST_RUN;
            ST_DRAIN: begin
                if (go_req) state_d = ST_RUN;
                else if (frame_end_i) state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pipe_en_o  = 1'b0;
        drain_o    = 1'b0;
        start_o    = 1'b0;
        done_set_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  start_o = go_req;
            ST_RUN:   pipe_en_o = 1'b1;
            ST_DRAIN: begin
                pipe_en_o  = 1'b1;
                drain_o    = 1'b1;
                done_set_o = !go_req && frame_end_i;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/dc_status_reg.sv
module dc_status_reg
    import dc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  dc_state_e         state_i,
    input  logic [STAT_W-1:1] ev_i,
    input  logic              done_set_i,
    input  logic              start_i,
    input  logic              w1c_wr_i,
    input  logic [STAT_W-1:0] w1c_data_i,
    input  logic [1:0]        load_mode_i,
    output logic [STAT_W-1:0] stat_o
);
    logic is_idle;
    assign is_idle = (state_i == ST_IDLE);

    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        localparam dc_clr_e KIND = clr_kind(b);
        logic set_b, clr_b, q_b;

        if (b == S_DONE) begin : g_set_done
            assign set_b = done_set_i;
        end else begin : g_set_evt
            assign set_b = ev_i[b] && !is_idle;
        end

        always_comb begin
            unique case (KIND)
                CLR_START: clr_b = start_i;
                CLR_W1C:   clr_b = w1c_wr_i && w1c_data_i[b];
                CLR_IDLE:  clr_b = is_idle;
                CLR_PAL:   clr_b = is_idle ||
                                   (w1c_wr_i && w1c_data_i[b] && load_mode_i == LM_PAL_ONLY);
                default:   clr_b = 1'b0;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_b <= 1'b0;
            else        q_b <= set_b | (q_b & ~clr_b);
        end

        assign stat_o[b] = q_b;
    end
endmodule

// File: rtl/dc_irq_gen.sv
module dc_irq_gen
    import dc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] stat_i,
    input  logic              ie_vsync_i,
    input  logic              ie_done_i,
    input  logic              ie_pal_i,
    input  logic              ie_line_i,
    output logic              irq_o
);
    logic pending, irq_q;

    always_comb begin
        pending = (stat_i[S_DONE]  && ie_done_i)
               || (stat_i[S_VSYNC] && ie_vsync_i)
               || (stat_i[S_PAL]   && ie_pal_i)
               || (stat_i[S_LINE]  && ie_line_i)
               ||  stat_i[S_SYNCL]
               ||  stat_i[S_FUF];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pending;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/dc_ctrl_core.sv
module dc_ctrl_core
    import dc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic [STAT_W-1:0] evt_i,
    output logic              pipe_en_o,
    output logic              drain_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(1);
    localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << C_RUN) | (32'h1F << C_IE_VSYNC)
                                   | (1 << C_PANEL) | (1 << C_LCLR) | (3 << C_LMODE));

    logic [DATA_W-1:0] ctrl_q;
    logic [STAT_W-1:0] stat_q;
    logic              ctrl_wr, stat_wr, start, done_set;
    dc_state_e         state;

    assign ctrl_wr = reg_wr_i && (reg_addr_i == ADDR_CTRL);
    assign stat_wr = reg_wr_i && (reg_addr_i == ADDR_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= reg_wdata_i & CTRL_MASK;
    end

    dc_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_wr_i    (ctrl_wr),
        .run_val_i   (reg_wdata_i[C_RUN]),
        .frame_end_i (evt_i[0]),
        .state_o     (state),
        .start_o     (start),
        .done_set_o  (done_set),
        .pipe_en_o   (pipe_en_o),
        .drain_o     (drain_o)
    );

    dc_status_reg u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .ev_i        (evt_i[STAT_W-1:1]),
        .done_set_i  (done_set),
        .start_i     (start),
        .w1c_wr_i    (stat_wr),
        .w1c_data_i  (reg_wdata_i[STAT_W-1:0]),
        .load_mode_i (ctrl_q[C_LMODE+1:C_LMODE]),
        .stat_o      (stat_q)
    );

    dc_irq_gen u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_i     (stat_q),
        .ie_vsync_i (ctrl_q[C_IE_VSYNC]),
        .ie_done_i  (ctrl_q[C_IE_DONE]),
        .ie_pal_i   (ctrl_q[C_IE_PAL]),
        .ie_line_i  (ctrl_q[C_IE_LINE]),
        .irq_o      (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_CTRL)      reg_rdata_o = ctrl_q;
        else if (reg_addr_i == ADDR_STAT) reg_rdata_o[STAT_W-1:0] = stat_q;
    end
endmodule

// File: rtl/dc_ctrl_core_chk.sv
module dc_ctrl_core_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_i,
    input logic [6:0]        evt_i,
    input logic              pipe_en_o,
    input logic              drain_o,
    input logic              irq_o,
    input logic [6:0]        stat_q,
    input logic [DATA_W-1:0] ctrl_q
);
    p_enable_runs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[0] |-> pipe_en_o);

    p_drain_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_o && evt_i[0] && !reg_wr_i) |=> (stat_q[0] && !pipe_en_o));

    p_done_low_running_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_en_o |-> !stat_q[0]);

    p_err_clear_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_en_o |=> (!stat_q[2] && !stat_q[5]));

    p_err_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[2] || stat_q[5]) |=> irq_o);

    p_drain_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        drain_o |-> (pipe_en_o && !ctrl_q[0]));
endmodule

bind dc_ctrl_core dc_ctrl_core_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_i  (reg_wr_i),
    .evt_i     (evt_i),
    .pipe_en_o (pipe_en_o),
    .drain_o   (drain_o),
    .irq_o     (irq_o),
    .stat_q    (stat_q),
    .ctrl_q    (ctrl_q)
);

// File: tb/dc_ctrl_core_bench.sv
module dc_ctrl_core_bench;
    localparam int DW = 32;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [6:0]    evt = '0;
    logic          pipe_en, drain, irq;
    int            n_run = 0;
    int            n_fail = 0;
    bit            finished = 1'b0;

    always #5 clk = ~clk;

    dc_ctrl_core #(.DATA_W(DW), .ADDR_W(AW)) u_dc_ctrl_core (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt),
        .pipe_en_o(pipe_en), .drain_o(drain), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr = 1'b0; evt = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        do_reset();
        rd(0, v); chk("R1 reset ctrl", v, 0);
        rd(1, v); chk("R1 reset stat", v, 0);
        chk("R2 reset pipe_en", 32'(pipe_en), 0);
        chk("R11 reset irq", 32'(irq), 0);
    endtask

    task automatic t_ctrl_fields();
        logic [DW-1:0] v;
        do_reset();
        wr_reg(0, 32'hFFFF_FFFE);
        rd(0, v); chk("R1 writable mask", v, 32'h0030_04FC);
        chk("R2 run=0 stays idle", 32'(pipe_en), 0);
    endtask

    task automatic t_run_drain_done();
        logic [DW-1:0] v;
        do_reset();
        wr_reg(0, 1);
        chk("R2 run starts pipe", 32'(pipe_en), 1);
        chk("R12 no drain in run", 32'(drain), 0);
        wr_reg(0, 0);
        rd(0, v); chk("R3 run bit reads 0", v, 0);
        chk("R3 pipe held in drain", 32'(pipe_en), 1);
        chk("R12 drain flag", 32'(drain), 1);
        repeat (3) @(negedge clk);
        chk("R3 still draining", 32'(pipe_en), 1);
        rd(1, v); chk("R3 no done yet", v, 0);
        pulse(7'h01);
        chk("R3 pipe stops at frame end", 32'(pipe_en), 0);
        chk("R12 drain ends", 32'(drain), 0);
        rd(1, v); chk("R3 done set", v, 32'h01);
        repeat (3) @(negedge clk);
        wr_reg(1, 32'h7F);
        rd(1, v); chk("R4 done survives write", v, 32'h01);
        wr_reg(0, 1);
        rd(1, v); chk("R4 done cleared on start", v, 0);
    endtask

    task automatic t_cancel();
        logic [DW-1:0] v;
        do_reset();
        wr_reg(0, 1);
        wr_reg(0, 0);
        wr_reg(0, 1);
        chk("R5 cancel leaves drain", 32'(drain), 0);
        pulse(7'h01);
        chk("R5 pipe still on", 32'(pipe_en), 1);
        rd(1, v); chk("R5 no done", v, 0);
    endtask

    task automatic t_events();
        logic [DW-1:0] v;
        do_reset();
        pulse(7'h7E);
        rd(1, v); chk("R6 idle events ignored", v, 0);
        wr_reg(0, 1);
        pulse(7'h01);
        rd(1, v); chk("R6 frame end no status in run", v, 0);
        pulse(7'h1A);
        rd(1, v); chk("R6 events latched", v, 32'h1A);
        wr_reg(1, 32'h08);
        rd(1, v); chk("R7 w1c acb", v, 32'h12);
        wr_reg(1, 32'h12);
        rd(1, v); chk("R7 w1c vsync line", v, 0);
    endtask

    task automatic t_errors();
        logic [DW-1:0] v;
        do_reset();
        wr_reg(0, 1);
        pulse(7'h24);
        rd(1, v); chk("R6 error bits set", v, 32'h24);
        wr_reg(1, 32'h24);
        rd(1, v); chk("R8 errors ignore write", v, 32'h24);
        wr_reg(0, 0);
        pulse(7'h01);
        rd(1, v); chk("R8 errors held at idle entry", v, 32'h25);
        @(negedge clk);
        rd(1, v); chk("R8 errors cleared in idle", v, 32'h01);
    endtask

    task automatic t_palette();
        logic [DW-1:0] v;
        do_reset();
        wr_reg(0, 32'h0010_0001);
        pulse(7'h40);
        rd(1, v); chk("R6 palette set", v, 32'h40);
        wr_reg(1, 32'h40);
        rd(1, v); chk("R9 w1c in palette mode", v, 0);
        pulse(7'h40);
        wr_reg(0, 32'h0020_0001);
        wr_reg(1, 32'h40);
        rd(1, v); chk("R9 write ignored frame mode", v, 32'h40);
        wr_reg(0, 32'h0020_0000);
        pulse(7'h01);
        @(negedge clk);
        rd(1, v); chk("R9 palette cleared idle", v, 32'h01);
    endtask

    task automatic t_set_wins();
        logic [DW-1:0] v;
        do_reset();
        wr_reg(0, 1);
        @(negedge clk);
        addr = 1; wdata = 32'h02; wr = 1'b1; evt = 7'h02;
        @(negedge clk);
        wr = 1'b0; evt = '0;
        rd(1, v); chk("R10 set beats clear", v, 32'h02);
    endtask

    task automatic t_irq();
        do_reset();
        wr_reg(0, 32'h05);
        pulse(7'h02);
        chk("R11 irq registered lag", 32'(irq), 0);
        @(negedge clk);
        chk("R11 vsync irq", 32'(irq), 1);
        wr_reg(1, 32'h02);
        @(negedge clk);
        chk("R11 irq drops", 32'(irq), 0);
        pulse(7'h18);
        @(negedge clk);
        chk("R11 masked line and acb", 32'(irq), 0);
        pulse(7'h04);
        @(negedge clk);
        chk("R11 sync lost unmasked", 32'(irq), 1);
    endtask

    initial begin
        t_reset();
        t_ctrl_fields();
        t_run_drain_done();
        t_cancel();
        t_events();
        t_errors();
        t_palette();
        t_set_wins();
        t_irq();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule